// File: doc/BRIEF.md
# Mesh Prefix Sum Array

This block computes inclusive prefix sums over a square grid of Q×Q cells. One load places N = Q·Q values into the cells in row-major order. Value index k (0-based) goes to row k/Q and column k mod Q. The grid then works through three phases. In each phase a cell reads only the cell to its left, the cell above it, or the last-column cell of the row above. At the end, every cell holds the wrapped sum of all values up to and including its own index.

The three phases run as follows:
1. **Row accumulation.** For Q-1 cycles, a sweep runs across the columns so that each row holds its own running sums.
2. **Last-column chain.** For Q-1 cycles, a chain runs down the last column so that each row's last cell holds the global total up to that point.
3. **Fix-up.** In one cycle, each row below the first adds the previous row's final last-column value to every cell except its last one.

Loading uses a valid/ready handshake. The block accepts one vector while idle and keeps `in_ready` low until the result has been taken. The result is offered with a valid/ready handshake that supports back-pressure: `out_valid` and `out_data` hold until `out_ready` is seen high at a clock edge. A plain `done` pin pulses for one cycle when the computation finishes.

Top module: `mesh_pfx_top`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: A vector is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From that edge until the result is taken, `in_ready` is 0.
- R3: A high `in_valid` while `in_ready` is 0 has no effect: the result delivered belongs to the vector accepted earlier.
- R4: Cell index k (0-based, k = row·Q + column) is driven on `out_data[k*W +: W]`. It equals the sum of input indices 0..k, where input index k is taken from `in_data[k*W +: W]`.
- R5: `out_valid` rises exactly 2·Q-1 clock edges after the accepting edge.
- R6: `done` is 1 for exactly one cycle, the first cycle in which `out_valid` is 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged. After an edge where both are 1, `out_valid` is 0 and `in_ready` is 1.
- R8: All sums wrap modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector offered |
| in_ready | output | 1 | Block is idle and will take a vector |
| in_data | input | Q*Q*W | Input values, index k at bits k*W +: W |
| out_valid | output | 1 | Prefix result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | Q*Q*W | Prefix sums, index k at bits k*W +: W |
| done | output | 1 | One-cycle pulse when computation ends |

## Verification
The assertions take for granted that the consumer may hold `out_ready` low for any length of time. They also assume that `in_valid` may be high at any time, including while the grid is busy. The stimulus deliberately pokes `in_valid` with a different vector during computation and stalls `out_ready` for several cycles. This keeps the checks of ignored loads and held results meaningful. Runs cover several grid sizes with random, all-zero, all-ones and single-value vectors.

// File: rtl/mesh_pfx_pkg.sv
package mesh_pfx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ROW  = 3'd1,
    PH_COL  = 3'd2,
    PH_FIX  = 3'd3,
    PH_HOLD = 3'd4
  } phase_t;
endpackage

// File: rtl/mesh_pfx_ctrl.sv
module mesh_pfx_ctrl
  import mesh_pfx_pkg::*;
#(
  parameter int Q  = 4,
  parameter int SW = (Q > 2) ? $clog2(Q) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  output phase_t        phase,
  output logic [SW-1:0] step,
  output logic          in_ready,
  output logic          out_valid,
  output logic          done
);
  localparam logic [SW-1:0] LAST_STEP = SW'(Q - 2);

  phase_t        phase_q, phase_d;
  logic [SW-1:0] step_q, step_d;
  logic          done_d;

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    done_d  = 1'b0;
    case (phase_q)
      PH_IDLE: if (in_valid) begin
        phase_d = PH_ROW;
        step_d  = '0;
      end
      PH_ROW: begin
        if (step_q == LAST_STEP) begin
          phase_d = PH_COL;
          step_d  = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      PH_COL: begin
        if (step_q == LAST_STEP) begin
          phase_d = PH_FIX;
          step_d  = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      PH_FIX: begin
        phase_d = PH_HOLD;
        done_d  = 1'b1;
      end
      PH_HOLD: if (out_ready) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      done    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      done    <= done_d;
    end
  end

  assign phase     = phase_q;
  assign step      = step_q;
  assign in_ready  = (phase_q == PH_IDLE);
  assign out_valid = (phase_q == PH_HOLD);

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP); // R5
  AST_LOAD_STARTS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (phase_q == PH_ROW && step_q == '0)); // R2
  AST_FIX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FIX) |=> (phase_q == PH_HOLD && done)); // R6
endmodule

// File: rtl/mesh_pfx_cell.sv
module mesh_pfx_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         add_en,
  input  logic [W-1:0] add_val,
  output logic [W-1:0] val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val <= '0;
    else if (ld)     val <= ld_val;
    else if (add_en) val <= val + add_val;
  end

  AST_NO_LOAD_AND_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld && add_en)); // R3
endmodule

// File: rtl/mesh_pfx_top.sv
module mesh_pfx_top
  import mesh_pfx_pkg::*;
#(
  parameter int Q = 4,
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [Q*Q*W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [Q*Q*W-1:0] out_data,
  output logic             done
);
  localparam int N  = Q * Q;
  localparam int SW = (Q > 2) ? $clog2(Q) : 1;

  phase_t        phase;
  logic [SW-1:0] step;
  logic          load;
  logic [W-1:0]  cv [N];

  initial begin
    if (Q < 2) $error("mesh_pfx_top needs Q >= 2");
  end

  mesh_pfx_ctrl #(.Q(Q), .SW(SW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .phase    (phase),
    .step     (step),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .done     (done)
  );

  assign load = in_valid && in_ready;

  for (genvar r = 0; r < Q; r++) begin : g_row
    for (genvar c = 0; c < Q; c++) begin : g_col
      localparam int K = r * Q + c;
      logic         row_hit, col_hit, fix_hit;
      logic [W-1:0] left_v, up_v, corner_v, add_v;

      if (c > 0) begin : g_left
        assign row_hit = (phase == PH_ROW) && (step == SW'(c - 1));
        assign left_v  = cv[K - 1];
      end else begin : g_noleft
        assign row_hit = 1'b0;
        assign left_v  = '0;
      end

      if (r > 0 && c == Q - 1) begin : g_up
        assign col_hit = (phase == PH_COL) && (step == SW'(r - 1));
        assign up_v    = cv[K - Q];
      end else begin : g_noup
        assign col_hit = 1'b0;
        assign up_v    = '0;
      end

      if (r > 0 && c < Q - 1) begin : g_fix
        assign fix_hit  = (phase == PH_FIX);
        assign corner_v = cv[r * Q - 1];
      end else begin : g_nofix
        assign fix_hit  = 1'b0;
        assign corner_v = '0;
      end

      assign add_v = row_hit ? left_v : (col_hit ? up_v : corner_v);

      mesh_pfx_cell #(.W(W)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (load),
        .ld_val (in_data[K*W +: W]),
        .add_en (row_hit || col_hit || fix_hit),
        .add_val(add_v),
        .val    (cv[K])
      );

      assign out_data[K*W +: W] = cv[K];
    end
  end

  AST_READY_OFF_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
  AST_RESULT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready)); // R7
  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done); // R6
  AST_BUSY_IGNORES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !out_valid) |=> !in_ready); // R3
endmodule

// File: tb/mesh_pfx_top_test.sv
module mesh_pfx_lane #(
  parameter int Q = 4,
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  output int   nchk,
  output int   nbad,
  output logic fin
);
  localparam int N = Q * Q;

  logic           in_valid, in_ready, out_valid, out_ready, done;
  logic [N*W-1:0] in_data, out_data;
  logic [W-1:0]   vin [N];
  logic [W-1:0]   expv [N];

  mesh_pfx_top #(.Q(Q), .W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s Q=%0d actual=%0h expected=%0h", req, Q, act, exp);
    end
  endtask

  function automatic void scan_model();
    logic [W-1:0] acc = '0;
    for (int k = 0; k < N; k++) begin
      acc = acc + vin[k];
      expv[k] = acc;
    end
  endfunction

  task automatic fill(input int mode);
    for (int k = 0; k < N; k++) begin
      case (mode)
        1: vin[k] = '1;
        2: vin[k] = '0;
        3: vin[k] = (k == 0) ? W'(7) : '0;
        default: vin[k] = W'($urandom);
      endcase
    end
  endtask

  task automatic run(input string req, input bit poke, input int hold);
    logic [N*W-1:0] packed_v, snap;
    int lat, bad_k;
    for (int k = 0; k < N; k++) packed_v[k*W +: W] = vin[k];
    scan_model();
    @(negedge clk);
    in_data  = packed_v;
    in_valid = 1'b1;
    chk(in_ready == 1'b1, "R2", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = poke;
    in_data  = ~packed_v;
    chk(in_ready == 1'b0, "R2", 64'(in_ready), 64'd0);
    lat = 0;
    while (!out_valid && lat < 4*Q + 8) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(lat == 2*Q - 1, "R5", 64'(lat), 64'(2*Q - 1));
    chk(done == 1'b1, "R6", 64'(done), 64'd1);
    bad_k = -1;
    for (int k = 0; k < N; k++)
      if (bad_k < 0 && out_data[k*W +: W] != expv[k]) bad_k = k;
    if (bad_k < 0) chk(1'b1, req, 64'd0, 64'd0);
    else chk(1'b0, req, 64'(out_data[bad_k*W +: W]), 64'(expv[bad_k]));
    snap = out_data;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R6", 64'(done), 64'd0);
      chk(out_valid && out_data == snap, "R7", 64'(out_valid), 64'd1);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R7", {62'd0, out_valid, in_ready}, 64'd1);
  endtask

  initial begin
    nchk = 0; nbad = 0; fin = 1'b0;
    in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    wait (rst_n === 1'b1);
    @(negedge clk);
    chk(in_ready && !out_valid && !done, "R1",
        {61'd0, in_ready, out_valid, done}, 64'h4);
    fill(3); run("R4", 1'b0, 2);
    fill(2); run("R4", 1'b1, 0);
    fill(1); run("R8", 1'b0, 1);
    for (int i = 0; i < 4; i++) begin
      fill(0);
      run(i[0] ? "R3" : "R4", i[0], i % 3);
    end
    fin = 1'b1;
  end
endmodule

module mesh_pfx_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c2, b2, c3, b3, c4, b4, c5, b5;
  logic f2, f3, f4, f5;
  int   total, bad;

  always #2 clk = ~clk;

  mesh_pfx_lane #(.Q(2)) lane2 (.clk(clk), .rst_n(rst_n), .nchk(c2), .nbad(b2), .fin(f2));
  mesh_pfx_lane #(.Q(3)) lane3 (.clk(clk), .rst_n(rst_n), .nchk(c3), .nbad(b3), .fin(f3));
  mesh_pfx_lane #(.Q(4)) uut   (.clk(clk), .rst_n(rst_n), .nchk(c4), .nbad(b4), .fin(f4));
  mesh_pfx_lane #(.Q(5)) lane5 (.clk(clk), .rst_n(rst_n), .nchk(c5), .nbad(b5), .fin(f5));

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed1234);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    fork
      wait (f2 && f3 && f4 && f5);
      repeat (20000) @(posedge clk);
    join_any
    disable fork;
    total = c2 + c3 + c4 + c5;
    bad   = b2 + b3 + b4 + b5;
    if (!(f2 && f3 && f4 && f5)) begin
      total++;
      bad++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule